// File: doc/BRIEF.md
# Quarter-Wave Interpolating Subcarrier Oscillator

This block regenerates a colour subcarrier as a pair of signed samples, sine and cosine, a quarter turn apart, for use as the in-phase and quadrature references of a chroma demodulator. A wide phase accumulator advances by a programmable frequency word on every enabled clock. An external burst-locking loop steers the output through a phase-correction input, which is added to the accumulated phase for each sample.

Amplitude comes from a small table that spans one quarter of a sine period. The two top phase bits pick the quadrant. Quadrant symmetry folds every phase onto that quarter, either by complementing the lookup phase or by negating the result. The next phase bits address the table. The bits below the table address are not thrown away: they weight a linear step toward the adjacent table entry. One sample enters per enabled clock, and both outputs leave together with a valid strobe after a fixed latency.

Top module: `nco_quarter_wave`

## Requirements
- R1: While reset is high, and on the first cycle after it, `vld_o` is 0 and `sin_o` and `cos_o` are 0.
- R2: `vld_o` is high exactly on the cycle that comes three rising edges after a rising edge at which `en` was high. Otherwise it is low. Sine and cosine of one sample appear on the same cycle.
- R3: The accumulator starts at 0 after reset. It adds `fcw` modulo 2^32 at each edge where `en` is high and holds its value otherwise. Each sample's phase is the accumulator value before that edge's addition, plus `poff`.
- R4: `poff` is applied only to the sample taken at the same edge. It is never added into the accumulator.
- R5: Table entry k (k = 0..256) is round(2047 * sin(pi/2 * k/256)). For a sample phase p, the quadrant is p[31:30], the address a is p[29:22] and the fraction f is p[21:14]. In quadrant 0 the output is T[a] + floor((T[a+1] - T[a]) * f / 256).
- R6: In quadrants 1 and 3, a and f are both bitwise complemented before the lookup and interpolation of R5.
- R7: In quadrants 2 and 3, the value obtained through R5 and R6 is negated. In quadrants 0 and 1 it is kept as it is.
- R8: `cos_o` equals the R5 to R7 result for the phase p + 2^30, taken from the same sample as `sin_o`.
- R9: At address 255, the upper neighbour is the endpoint T[256] = 2047, so values stay continuous at quadrant boundaries. The magnitude of either output never exceeds 2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Take one sample and advance the phase |
| fcw | input | 32 | Frequency word added to the phase per enabled clock |
| poff | input | 32 | Phase correction added to the current sample |
| sin_o | output | 12 | Signed sine sample |
| cos_o | output | 12 | Signed cosine sample |
| vld_o | output | 1 | Sample strobe for `sin_o` and `cos_o` |

## Verification
Every result falls due three rising edges after the edge that samples `en`, `fcw` and `poff`. The bench drives inputs at the falling edge. At each later falling edge, before it drives the next inputs, it compares the outputs with the sample it drove three falling edges earlier, using a three-deep history of drive values and model phases. The valid strobe is compared on every cycle, including cycles with enable low. Sine and cosine are compared on the same cycle as the strobe, so a missing or extra pipeline stage, or skew between the two paths, shows up as a mismatch.

// File: rtl/nco_pkg.sv
package nco_pkg;

   localparam real HALF_PI = 1.5707963267948966;

   // Rounded magnitude of the quarter-wave sample at index k of 2**addr_w steps.
   function automatic int quarter_entry(input int k, input int addr_w, input int out_w);
      real amp;
      real ang;
      amp = (2.0 ** (out_w - 1)) - 1.0;
      ang = HALF_PI * real'(k) / (2.0 ** addr_w);
      return $rtoi(amp * $sin(ang) + 0.5);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [PHASE_W-1:0] fcw,
   input  logic [PHASE_W-1:0] poff,
   output logic [PHASE_W-1:0] phase_q,
   output logic               vld_q
);

   logic [PHASE_W-1:0] acc;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc     <= '0;
         phase_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= en;
         if (en) begin
            acc     <= acc + fcw;
            phase_q <= acc + poff;
         end
      end
   end

   // R3: the accumulator steps by the frequency word on enabled edges only
   a_r3_acc_step: assert property (@(posedge clk) disable iff (rst)
      en |=> (acc == $past(acc) + $past(fcw)));
   a_r3_acc_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc));

endmodule

// File: rtl/nco_quarter_lut.sv
module nco_quarter_lut #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 8,
   parameter int FRAC_W  = 8,
   parameter int OUT_W   = 12
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] phase,
   output logic [OUT_W-2:0]   lo_q,
   output logic [OUT_W-2:0]   hi_q,
   output logic [FRAC_W-1:0]  frac_q,
   output logic               neg_q
);
   import nco_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;
   localparam int MAG_W = OUT_W - 1;
   localparam int A_TOP = PHASE_W - 3;
   localparam int F_TOP = PHASE_W - 3 - ADDR_W;

   logic [MAG_W-1:0] rom [0:DEPTH];

   for (genvar k = 0; k <= DEPTH; k++) begin : g_rom
      assign rom[k] = MAG_W'(quarter_entry(k, ADDR_W, OUT_W));
   end

   logic [1:0]        quad;
   logic [ADDR_W-1:0] addr;
   logic [FRAC_W-1:0] frac;
   logic [ADDR_W:0]   addr_nx;

   always_comb begin
      quad = phase[PHASE_W-1 -: 2];
      addr = phase[A_TOP -: ADDR_W];
      frac = phase[F_TOP -: FRAC_W];
      if (quad[0]) begin
         addr = ~addr;
         frac = ~frac;
      end
      addr_nx = {1'b0, addr} + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q   <= '0;
         hi_q   <= '0;
         frac_q <= '0;
         neg_q  <= 1'b0;
      end else begin
         lo_q   <= rom[{1'b0, addr}];
         hi_q   <= rom[addr_nx];
         frac_q <= frac;
         neg_q  <= quad[1];
      end
   end

   // R9: neighbours on a rising quarter wave never decrease, including the endpoint
   a_r9_neighbour_order: assert property (@(posedge clk) disable iff (rst)
      hi_q >= lo_q);

endmodule

// File: rtl/nco_interp.sv
module nco_interp #(
   parameter int FRAC_W = 8,
   parameter int OUT_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [OUT_W-2:0]        lo,
   input  logic [OUT_W-2:0]        hi,
   input  logic [FRAC_W-1:0]       frac,
   input  logic                    neg,
   output logic signed [OUT_W-1:0] y_q
);

   localparam int MAG_W = OUT_W - 1;
   localparam int PRD_W = MAG_W + FRAC_W;
   localparam logic signed [OUT_W-1:0] AMP = OUT_W'((1 << (OUT_W - 1)) - 1);

   logic [MAG_W-1:0]       diff;
   logic [PRD_W-1:0]       prod;
   logic [MAG_W-1:0]       mag;
   logic signed [OUT_W-1:0] smag;

   always_comb begin
      diff = hi - lo;
      prod = PRD_W'(diff) * PRD_W'(frac);
      mag  = lo + prod[PRD_W-1:FRAC_W];
      smag = $signed({1'b0, mag});
   end

   always_ff @(posedge clk) begin
      if (rst) y_q <= '0;
      else     y_q <= neg ? -smag : smag;
   end

   // R7: sign follows the half-cycle bit
   a_r7_neg_half: assert property (@(posedge clk) disable iff (rst)
      neg |=> (y_q <= 0));
   a_r7_pos_half: assert property (@(posedge clk) disable iff (rst)
      !neg |=> (y_q >= 0));
   // R9: amplitude bound
   a_r9_bound: assert property (@(posedge clk) disable iff (rst)
      (y_q <= AMP) && (y_q >= -AMP));

endmodule

// File: rtl/nco_quarter_wave.sv
module nco_quarter_wave #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 8,
   parameter int FRAC_W  = 8,
   parameter int OUT_W   = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [PHASE_W-1:0]      fcw,
   input  logic [PHASE_W-1:0]      poff,
   output logic signed [OUT_W-1:0] sin_o,
   output logic signed [OUT_W-1:0] cos_o,
   output logic                    vld_o
);

   localparam int MAG_W = OUT_W - 1;
   localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);

   if (PHASE_W < 2 + ADDR_W + FRAC_W) begin : g_bad_split
      $error("phase width too narrow for quadrant, address and fraction bits");
   end
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("table address width out of range");
   end
   if (OUT_W < 4 || FRAC_W < 1) begin : g_bad_out
      $error("output or fraction width out of range");
   end

   logic [PHASE_W-1:0] phase;
   logic               v1, v2, v3;

   nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk(clk), .rst(rst), .en(en), .fcw(fcw), .poff(poff),
      .phase_q(phase), .vld_q(v1)
   );

   logic signed [OUT_W-1:0] wave [2];

   for (genvar g = 0; g < 2; g++) begin : g_path
      logic [PHASE_W-1:0] ph;
      logic [MAG_W-1:0]   lo, hi;
      logic [FRAC_W-1:0]  fr;
      logic               ng;

      assign ph = (g == 0) ? phase : phase + QUARTER;

      nco_quarter_lut #(
         .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)
      ) u_lut (
         .clk(clk), .rst(rst), .phase(ph),
         .lo_q(lo), .hi_q(hi), .frac_q(fr), .neg_q(ng)
      );

      nco_interp #(.FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_interp (
         .clk(clk), .rst(rst), .lo(lo), .hi(hi), .frac(fr), .neg(ng),
         .y_q(wave[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v2 <= 1'b0;
         v3 <= 1'b0;
      end else begin
         v2 <= v1;
         v3 <= v2;
      end
   end

   assign sin_o = wave[0];
   assign cos_o = wave[1];
   assign vld_o = v3;

   // R2: strobe follows the enable by exactly three edges
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                 since_rst <= '0;
      else if (since_rst != 3) since_rst <= since_rst + 1'b1;
   end

   a_r2_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> (vld_o == $past(en, 3)));

   // R1: quiet outputs right after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (!vld_o && sin_o == 0 && cos_o == 0));

endmodule

// File: tb/nco_quarter_wave_tb.sv
`timescale 1ns/1ps
module nco_quarter_wave_tb;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               en = 1'b0;
   logic [31:0]        fcw = '0;
   logic [31:0]        poff = '0;
   logic signed [11:0] sin_o, cos_o;
   logic               vld_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int          tab [0:256];
   logic [31:0] acc_m;
   bit          h_v  [0:2];
   logic [31:0] h_ph [0:2];
   string       sec;

   always #2.5 clk = ~clk;

   nco_quarter_wave u_dut (
      .clk(clk), .rst(rst), .en(en), .fcw(fcw), .poff(poff),
      .sin_o(sin_o), .cos_o(cos_o), .vld_o(vld_o)
   );

   function automatic int ref_wave(input logic [31:0] ph);
      logic [1:0] q;
      int a, f, lo, hi, m;
      q = ph[31:30];
      a = int'(ph[29:22]);
      f = int'(ph[21:14]);
      if (q[0]) begin
         a = 255 - a;
         f = 255 - f;
      end
      lo = tab[a];
      hi = tab[a + 1];
      m  = lo + ((hi - lo) * f) / 256;
      return q[1] ? -m : m;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s [%s] actual=%0d expected=%0d", tag, sec, act, exp);
      end
   endtask

   task automatic check_out();
      string qt;
      chk("R2 valid", int'(vld_o), int'(h_v[2]));
      if (h_v[2]) begin
         case (h_ph[2][31:30])
            2'd0:    qt = "R5 sine";
            2'd1:    qt = "R6 sine";
            default: qt = "R7 sine";
         endcase
         chk(qt, int'(sin_o), ref_wave(h_ph[2]));
         chk("R8 cosine", int'(cos_o), ref_wave(h_ph[2] + 32'h4000_0000));
      end
   endtask

   task automatic step(input bit e, input logic [31:0] f, input logic [31:0] p);
      @(negedge clk);
      check_out();
      h_v[2]  = h_v[1];  h_ph[2] = h_ph[1];
      h_v[1]  = h_v[0];  h_ph[1] = h_ph[0];
      h_v[0]  = e;       h_ph[0] = acc_m + p;
      if (e) acc_m = acc_m + f;
      en = e; fcw = f; poff = p;
   endtask

   initial begin
      for (int k = 0; k <= 256; k++)
         tab[k] = $rtoi(2047.0 * $sin(1.5707963267948966 * real'(k) / 256.0) + 0.5);
      for (int i = 0; i < 3; i++) begin
         h_v[i] = 1'b0;
         h_ph[i] = '0;
      end
      acc_m = '0;
      sec = "R1";
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", int'(vld_o), 0);
      chk("R1 sine in reset", int'(sin_o), 0);
      chk("R1 cosine in reset", int'(cos_o), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 valid after reset", int'(vld_o), 0);
      chk("R1 sine after reset", int'(sin_o), 0);

      // R5: every table address in every quadrant, then a fine fractional sweep
      sec = "R5 sweep";
      for (int i = 0; i < 1024; i++) step(1'b1, 32'h0040_0000, 32'h0);
      for (int i = 0; i < 2048; i++) step(1'b1, 32'h0040_1C00 + 32'(i & 7), 32'h0);

      // R3: gaps in the enable, wrapping steps
      sec = "R3 gaps";
      for (int i = 0; i < 600; i++) step((i % 3) != 0, 32'h1234_5679, 32'h0);

      // R4: per-sample correction must not accumulate
      sec = "R4 offset";
      for (int i = 0; i < 600; i++) step(1'b1, 32'h0010_0000, 32'(i) * 32'h0765_4321);

      // R9: quadrant edges and the table endpoint
      sec = "R9 edges";
      step(1'b1, 32'h0, 32'h3FFF_C000 - acc_m);
      step(1'b1, 32'h0, 32'h4000_0000 - acc_m);
      step(1'b1, 32'h0, 32'h7FFF_FFFF - acc_m);
      step(1'b1, 32'h0, 32'hBFFF_C000 - acc_m);
      step(1'b1, 32'h0, 32'hFFFF_FFFF - acc_m);
      step(1'b1, 32'h0, 32'h0000_0000 - acc_m);
      for (int i = 0; i < 4; i++) step(1'b0, 32'h0, 32'h0);
      // the endpoint 2047 as upper neighbour at address 255, fraction 255
      chk("R9 endpoint", ref_wave(32'h3FFF_C000),
          tab[255] + ((2047 - tab[255]) * 255) / 256);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule